// File: doc/BRIEF.md
# Pre-Adder Signed Multiplier Front End

This block is the multiply half of an arithmetic slice. It takes a wide A operand, a 24-bit B operand and a 27-bit D operand. Each input goes through its own registers, and A and B each have a two-deep register chain. A 27-bit pre-adder adds D to a chosen path operand, or subtracts D from it. The path operand is either the low 27 bits of A or the sign-extended B operand. The sum then drives one multiplier input, or both of them when a square is requested.

The multiplier is a signed 27 × 24 array. Its 51-bit product can be negated on request and is captured in a post-multiply register. An output register then presents it sign-extended to 58 bits.

A 5-bit mode word controls the datapath cycle by cycle. It chooses which A and B register stage feeds the datapath, masks the path operand, gates D and picks add or subtract. Every register stage has its own clock enable, so the surrounding logic can balance latency against the operands it feeds.

Top module: `preadd_mult_fe`

## Requirements
- R1: A synchronous active-high reset clears every register; `p_out` reads zero while reset is held and in the first cycle after it is released.
- R2: Mode bit 0 selects the A register stage: 0 uses the first stage, 1 uses the second. Bits 33:27 of A never affect the result.
- R3: Mode bit 4 selects the B register stage in the same way: 0 uses the first stage, 1 uses the second.
- R4: The pre-adder forms path + D when mode bit 3 is 0 and path − D when it is 1, wrapping to 27 bits. The D term is the D register when mode bit 2 is 1 and zero otherwise.
- R5: Mode bit 1 set to 1 replaces the pre-adder path operand with zero.
- R6: With `pre_sel_b` = 0 the path is A[26:0] and the product is sum × B. With `pre_sel_b` = 1 the path is B sign-extended to 27 bits and the product is A[26:0] × sum[23:0]. Both operands are signed.
- R7: With `square` = 1 the product is sum × sum[23:0], which is the exact square whenever the sum lies in [−2^23, 2^23).
- R8: With `negate` = 1 the product is negated before the post-multiply register, including the extreme operand pair −2^26 × −2^23.
- R9: Each register (A stage 1, A stage 2, B stage 1, B stage 2, D, M, P) loads only in a cycle where its own enable is 1 and otherwise holds its value.
- R10: A product formed from the register values before clock edge k is on `p_out` after edge k+1. `p_out` is the 51-bit product sign-extended to 58 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_a1 | input | 1 | Enable of A stage 1 |
| ce_a2 | input | 1 | Enable of A stage 2 |
| ce_b1 | input | 1 | Enable of B stage 1 |
| ce_b2 | input | 1 | Enable of B stage 2 |
| ce_d | input | 1 | Enable of D register |
| ce_m | input | 1 | Enable of post-multiply register |
| ce_p | input | 1 | Enable of output register |
| mode | input | 5 | [0] A stage, [1] path mask, [2] D enable, [3] subtract, [4] B stage |
| pre_sel_b | input | 1 | 0: A feeds the pre-adder, 1: B feeds the pre-adder |
| square | input | 1 | Route the pre-adder sum to both multiplier inputs |
| negate | input | 1 | Negate the product |
| a_in | input | 34 | A operand; only bits 26:0 reach the multiplier |
| b_in | input | 24 | B operand, signed |
| d_in | input | 27 | D operand, signed |
| p_out | output | 58 | Registered product, sign-extended |

## Verification
The bench builds the block with its default widths: a 34-bit A, a 24-bit B, a 27-bit D and pre-adder, and a 58-bit output. At these widths the full 27 × 24 signed product fits in a 64-bit integer, so the reference model computes exact expected values. That makes the most negative operand pair and the wrap of the 27-bit pre-adder reachable.

The stimulus runs in phases, one per requirement, and a last phase randomises every control. Random enable patterns walk the two-deep chains through their hold-and-advance combinations.

// File: rtl/mulfe_pkg.sv
package mulfe_pkg;
    localparam int A_W   = 34;
    localparam int B_W   = 24;
    localparam int D_W   = 27;
    localparam int P_W   = 58;
    localparam int MODE_W = 5;
    // mode bit positions
    localparam int MB_ASTAGE = 0;
    localparam int MB_MASK   = 1;
    localparam int MB_DEN    = 2;
    localparam int MB_SUB    = 3;
    localparam int MB_BSTAGE = 4;
endpackage

// File: rtl/mulfe_inreg.sv
module mulfe_inreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce1,
    input  logic         ce2,
    input  logic [W-1:0] din,
    output logic [W-1:0] q1,
    output logic [W-1:0] q2
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce1) st_d.s1 = din;
        if (ce2) st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q1 = st_q.s1;
    assign q2 = st_q.s2;
endmodule

// File: rtl/mulfe_preadd.sv
module mulfe_preadd #(
    parameter int SW = 27,
    parameter int BW = 24
) (
    input  logic [SW-1:0] path_a,
    input  logic [BW-1:0] path_b,
    input  logic [SW-1:0] dval,
    input  logic          use_b,
    input  logic          mask,
    input  logic          d_en,
    input  logic          sub,
    output logic [SW-1:0] sum
);
    logic [SW-1:0] opnd, dterm;

    always_comb begin
        opnd  = use_b ? {{(SW-BW){path_b[BW-1]}}, path_b} : path_a;
        if (mask) opnd = '0;
        dterm = d_en ? dval : '0;
        sum   = sub ? (opnd - dterm) : (opnd + dterm);
    end
endmodule

// File: rtl/mulfe_mult.sv
module mulfe_mult #(
    parameter int XW = 27,
    parameter int YW = 24,
    localparam int RW = XW + YW
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          neg,
    output logic [RW-1:0] prod
);
    logic signed [RW-1:0] raw;

    always_comb begin
        raw  = RW'($signed(x)) * RW'($signed(y));
        prod = neg ? (-raw) : raw;
    end
endmodule

// File: rtl/preadd_mult_fe.sv
module preadd_mult_fe
    import mulfe_pkg::*;
#(
    parameter int AW = A_W,
    parameter int BW = B_W,
    parameter int DW = D_W,
    parameter int PW = P_W,
    localparam int MW = DW + BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_a1,
    input  logic              ce_a2,
    input  logic              ce_b1,
    input  logic              ce_b2,
    input  logic              ce_d,
    input  logic              ce_m,
    input  logic              ce_p,
    input  logic [MODE_W-1:0] mode,
    input  logic              pre_sel_b,
    input  logic              square,
    input  logic              negate,
    input  logic [AW-1:0]     a_in,
    input  logic [BW-1:0]     b_in,
    input  logic [DW-1:0]     d_in,
    output logic [PW-1:0]     p_out
);
    typedef struct packed {
        logic [DW-1:0] dr;
        logic [MW-1:0] m;
        logic [PW-1:0] p;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic [AW-1:0] a_s1, a_s2;
    logic [BW-1:0] b_s1, b_s2;
    logic [DW-1:0] a_low, pre_sum, mx;
    logic [BW-1:0] b_cur, my;
    logic [MW-1:0] prod;
    logic [MW-1:0] m_q;

    mulfe_inreg #(.W(AW)) u_areg (
        .clk(clk), .rst(rst), .ce1(ce_a1), .ce2(ce_a2),
        .din(a_in), .q1(a_s1), .q2(a_s2)
    );

    mulfe_inreg #(.W(BW)) u_breg (
        .clk(clk), .rst(rst), .ce1(ce_b1), .ce2(ce_b2),
        .din(b_in), .q1(b_s1), .q2(b_s2)
    );

    always_comb begin
        a_low = mode[MB_ASTAGE] ? a_s2[DW-1:0] : a_s1[DW-1:0];
        b_cur = mode[MB_BSTAGE] ? b_s2 : b_s1;
    end

    mulfe_preadd #(.SW(DW), .BW(BW)) u_pre (
        .path_a(a_low), .path_b(b_cur), .dval(pp_q.dr),
        .use_b(pre_sel_b), .mask(mode[MB_MASK]), .d_en(mode[MB_DEN]),
        .sub(mode[MB_SUB]), .sum(pre_sum)
    );

    // operand routing into the multiplier
    always_comb begin
        if (square) begin
            mx = pre_sum;
            my = pre_sum[BW-1:0];
        end else if (pre_sel_b) begin
            mx = a_low;
            my = pre_sum[BW-1:0];
        end else begin
            mx = pre_sum;
            my = b_cur;
        end
    end

    mulfe_mult #(.XW(DW), .YW(BW)) u_mul (
        .x(mx), .y(my), .neg(negate), .prod(prod)
    );

    always_comb begin
        pp_d = pp_q;
        if (ce_d) pp_d.dr = d_in;
        if (ce_m) pp_d.m  = prod;
        if (ce_p) pp_d.p  = {{(PW-MW){pp_q.m[MW-1]}}, pp_q.m};
    end

    always_ff @(posedge clk) begin
        if (rst) pp_q <= '0;
        else     pp_q <= pp_d;
    end

    assign m_q   = pp_q.m;
    assign p_out = pp_q.p;
endmodule

// File: rtl/mulfe_chk.sv
module mulfe_chk #(
    parameter int PW = 58,
    parameter int MW = 51,
    parameter int MODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_m,
    input logic              ce_p,
    input logic [MODE_W-1:0] mode,
    input logic              pre_sel_b,
    input logic              square,
    input logic [MW-1:0]     m_q,
    input logic [PW-1:0]     p_out
);
    // R1: output is zero in the first cycle after reset release
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (p_out == '0));

    // R9: output register holds when its enable is low
    a_r9_hold_p: assert property (@(posedge clk) disable iff (rst)
        !ce_p |=> $stable(p_out));

    // R10: upper output bits replicate the product sign
    a_r10_sext: assert property (@(posedge clk) disable iff (rst)
        p_out[PW-1:MW-1] == {(PW-MW+1){p_out[MW-1]}});

    // R5: masked path with D gated off gives a zero product
    a_r5_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (ce_m && mode[1] && !mode[2] && !pre_sel_b) |=> (m_q == '0));

    // R7: squaring a zero sum gives zero
    a_r7_square_zero: assert property (@(posedge clk) disable iff (rst)
        (ce_m && square && mode[1] && !mode[2]) |=> (m_q == '0));
endmodule

bind preadd_mult_fe mulfe_chk #(.PW(PW), .MW(MW), .MODE_W(mulfe_pkg::MODE_W)) u_chk (
    .clk(clk), .rst(rst), .ce_m(ce_m), .ce_p(ce_p), .mode(mode),
    .pre_sel_b(pre_sel_b), .square(square), .m_q(m_q), .p_out(p_out)
);

// File: tb/sim_preadd_mult_fe.sv
module sim_preadd_mult_fe;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_m, ce_p;
    logic [4:0]  mode;
    logic        pre_sel_b, square, negate;
    logic [33:0] a_in;
    logic [23:0] b_in;
    logic [26:0] d_in;
    logic [57:0] p_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    preadd_mult_fe u0 (
        .clk(clk), .rst(rst), .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1),
        .ce_b2(ce_b2), .ce_d(ce_d), .ce_m(ce_m), .ce_p(ce_p), .mode(mode),
        .pre_sel_b(pre_sel_b), .square(square), .negate(negate),
        .a_in(a_in), .b_in(b_in), .d_in(d_in), .p_out(p_out)
    );

    function automatic longint sx(longint v, int w);
        longint r = v & ((longint'(1) << w) - 1);
        if (((r >> (w - 1)) & 1) != 0) r = r - (longint'(1) << w);
        return r;
    endfunction

    // behavioural reference state
    longint ra1, ra2, rb1, rb2, rd, rm, rp;

    function automatic longint ref_prod();
        longint av, bv, path, dv, s, x, y, pr;
        av = sx(mode[0] ? ra2 : ra1, 27);
        bv = sx(mode[4] ? rb2 : rb1, 24);
        path = pre_sel_b ? bv : av;
        if (mode[1]) path = 0;
        dv = mode[2] ? rd : 0;
        s = sx(mode[3] ? path - dv : path + dv, 27);
        if (square) begin x = s; y = sx(s, 24); end
        else if (pre_sel_b) begin x = av; y = sx(s, 24); end
        else begin x = s; y = bv; end
        pr = x * y;
        if (negate) pr = -pr;
        return pr;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ra1 = 0; ra2 = 0; rb1 = 0; rb2 = 0; rd = 0; rm = 0; rp = 0;
        end else begin
            longint np;
            np = ref_prod();
            if (ce_p)  rp = rm;
            if (ce_m)  rm = np;
            if (ce_d)  rd = sx(longint'(d_in), 27);
            if (ce_a2) ra2 = ra1;
            if (ce_a1) ra1 = longint'(a_in);
            if (ce_b2) rb2 = rb1;
            if (ce_b1) rb1 = longint'(b_in);
        end
    end

    task automatic check_out(string t);
        logic [57:0] exp_v;
        exp_v = rp[57:0];
        checks++;
        if (p_out !== exp_v) begin
            errors++;
            $display("FAIL %s p_out=%h expected=%h", t, p_out, exp_v);
        end
    endtask

    task automatic all_ce(bit v);
        ce_a1 = v; ce_a2 = v; ce_b1 = v; ce_b2 = v; ce_d = v; ce_m = v; ce_p = v;
    endtask

    // kind selects which controls are randomised
    task automatic run_phase(string t, int n, int kind);
        tag = t;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_out(t);
            a_in = {$urandom, $urandom} & 34'h3_FFFF_FFFF;
            b_in = 24'($urandom);
            d_in = 27'($urandom);
            all_ce(1'b1);
            mode = 5'b00000; pre_sel_b = 0; square = 0; negate = 0;
            case (kind)
                2: mode[0] = 1'($urandom);
                3: begin mode[4] = 1'($urandom); mode[2] = 1; end
                4: begin mode[2] = 1; mode[3] = 1'($urandom); mode[0] = 1'($urandom); end
                5: begin mode[1] = 1'($urandom); mode[2] = 1'($urandom); end
                6: begin pre_sel_b = 1; mode = 5'($urandom); end
                7: begin
                    square = 1; mode[2] = 1; mode[3] = 1'($urandom);
                    a_in = 34'(sx(longint'($urandom), 20)); d_in = 27'(sx(longint'($urandom), 20));
                end
                8: begin
                    negate = 1'($urandom);
                    if (i % 4 == 0) begin a_in = 34'h3_FC00_0000; b_in = 24'h80_0000; end
                end
                9: begin
                    mode = 5'($urandom);
                    {ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_m, ce_p} = 7'($urandom);
                end
                default: begin
                    mode = 5'($urandom); pre_sel_b = 1'($urandom);
                    square = 1'($urandom); negate = 1'($urandom);
                end
            endcase
        end
    endtask

    initial begin
        all_ce(1'b1);
        mode = '0; pre_sel_b = 0; square = 0; negate = 0;
        a_in = 34'h1_2345_6789; b_in = 24'h12_3456; d_in = 27'h111_1111;
        repeat (4) @(negedge clk);
        checks++;
        if (p_out !== '0) begin
            errors++;
            $display("FAIL R1 p_out=%h expected=0 during reset", p_out);
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if (p_out !== '0) begin
            errors++;
            $display("FAIL R1 p_out=%h expected=0 after reset", p_out);
        end
        run_phase("R2", 40, 2);
        run_phase("R3", 40, 3);
        run_phase("R4", 40, 4);
        run_phase("R5", 40, 5);
        run_phase("R6", 40, 6);
        run_phase("R7", 40, 7);
        run_phase("R8", 40, 8);
        run_phase("R9", 200, 9);
        run_phase("R10", 300, 10);
        repeat (3) begin
            @(negedge clk);
            check_out("R10");
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule